// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt sources into a status register that holds each event until software clears it. Software reaches the block through a plain synchronous register port: a word index, write enable, write data, read enable and registered read data. Software can enable or mask each source. Each mask bit can be changed on its own through set and clear aliases, with no read-modify-write. Software acknowledges serviced sources and reads back the number of the most urgent pending source. A single registered request line goes to the processor.

Each source is built as level-sensitive or rising-edge-sensitive through a parameter mask. A two-bit master register gates the block. One bit lets the request reach the processor. The other bit hands status updates over to the hardware sources. Before that hand-over, software may raise test interrupts by writing the status register. After it, the hand-over cannot be undone until reset.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and master read as zero, `irq_o` is low, and the vector word (index 6) reads 32'hFFFF_FFFF.
- R2: While the hardware-enable bit is 1, a source sets its status bit in the clock edge where it is sampled active. A level source is active while it is high. An edge source (its `SRC_EDGE` bit is 1) is active only in the first cycle after a low-to-high change. A status bit stays set until it is acknowledged. The status word is index 0.
- R3: While the hardware-enable bit is 0, writing the status word sets each bit written as 1, and sources are ignored. Once hardware-enable is 1, writes to the status word have no effect.
- R4: The pending word (index 1) reads as status AND enable. Writes to it have no effect.
- R5: Writing word 2 loads the enable mask. Writing word 4 sets every enable bit written as 1. Writing word 5 clears every enable bit written as 1. All other enable bits are unchanged.
- R6: Writing word 3 clears each status bit written as 1. If a source is active on the same edge, its status bit stays set.
- R7: The vector word (index 6) returns the lowest index whose pending bit is 1, zero-extended. When no bit is pending it returns all ones.
- R8: In the master word (index 7), bit 0 is the request enable and bit 1 is the hardware enable. Bit 0 is freely writable. Bit 1 can only be set, and it stays 1 until reset. The word reads back {30'b0, hw_en, req_en}.
- R9: `irq_o` is a register. On each edge it loads request-enable AND (any pending bit), taken from the state before that edge.
- R10: Bits at or above `NUM_SRC` read as zero in the status, pending and enable words, and writes to them have no effect.
- R11: `rd_data_o` is loaded on the edge where `rd_en_i` is 1 and holds its value otherwise. Words 3, 4 and 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Word index (byte offset / 4) |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| src_i | input | NUM_SRC | Interrupt source inputs |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A register write or a source event changes state on the edge where it is sampled. A read issued in the following cycle shows the new value in `rd_data_o`, one edge after the read strobe. `irq_o` lags the state it reflects by one further edge. The bench drives every input at the falling edge and lets one rising edge pass. At that edge its reference model computes the read value and the request value from the state before the edge, and only then advances. It compares the outputs at the next falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned WIDX_W = 3;

  // Word index on the register port; the order is the fixed address map.
  typedef enum logic [WIDX_W-1:0] {
    W_STAT = 3'd0,
    W_PEND = 3'd1,
    W_ENA  = 3'd2,
    W_ACK  = 3'd3,
    W_SETE = 3'd4,
    W_CLRE = 3'd5,
    W_VEC  = 3'd6,
    W_MST  = 3'd7
  } word_sel_e;
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int unsigned N        = 32,
  parameter logic [31:0] SRC_EDGE = 32'h0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    if (SRC_EDGE[g]) begin : g_edge
      assign evt_o[g] = src_i[g] & ~prev_q[g];
    end else begin : g_level
      assign evt_o[g] = src_i[g];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // Scan from the top down so the lowest set index is written last.
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_vec_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  word_sel_e    sel_i,
  input  logic [N-1:0] wd_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] ena_o,
  output logic         req_en_o,
  output logic         hw_en_o
);
  logic [N-1:0] stat_q, ena_q;
  logic         req_en_q, hw_en_q;
  logic [N-1:0] ack_mask, sw_set, hw_set;

  assign ack_mask = (wr_en_i && sel_i == W_ACK) ? wd_i : '0;
  assign sw_set   = (wr_en_i && sel_i == W_STAT && !hw_en_q) ? wd_i : '0;
  assign hw_set   = hw_en_q ? evt_i : '0;

  // Clear first, then OR in new events so a same-edge event wins.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~ack_mask) | sw_set | hw_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= '0;
    end else if (wr_en_i) begin
      case (sel_i)
        W_ENA:   ena_q <= wd_i;
        W_SETE:  ena_q <= ena_q | wd_i;
        W_CLRE:  ena_q <= ena_q & ~wd_i;
        default: ena_q <= ena_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_en_q <= 1'b0;
      hw_en_q  <= 1'b0;
    end else if (wr_en_i && sel_i == W_MST) begin
      req_en_q <= wd_i[0];
      hw_en_q  <= hw_en_q | wd_i[1];
    end
  end

  assign stat_o   = stat_q;
  assign ena_o    = ena_q;
  assign req_en_o = req_en_q;
  assign hw_en_o  = hw_en_q;

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(ack_mask)) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_mask != '0) |=> ((stat_q & $past(ack_mask & ~hw_set)) == '0)); // R6
  AST_HW_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en_q |=> hw_en_q); // R8
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter logic [31:0] SRC_EDGE = 32'h0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WIDX_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                rd_en_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic                irq_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  word_sel_e          sel;
  logic [NUM_SRC-1:0] evt, stat, ena, pend;
  logic               req_en, hw_en, vec_any;
  logic [IDX_W-1:0]   vec_idx;
  logic [REG_W-1:0]   rd_mux, rd_q;
  logic               irq_q;

  assign sel = word_sel_e'(addr_i);

  irq_src_detect #(.N(NUM_SRC), .SRC_EDGE(SRC_EDGE)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .evt_o  (evt)
  );

  irq_regfile #(.N(NUM_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel),
    .wd_i     (wr_data_i[NUM_SRC-1:0]),
    .evt_i    (evt),
    .stat_o   (stat),
    .ena_o    (ena),
    .req_en_o (req_en),
    .hw_en_o  (hw_en)
  );

  assign pend = stat & ena;

  irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i (pend),
    .any_o  (vec_any),
    .idx_o  (vec_idx)
  );

  always_comb begin
    case (sel)
      W_STAT:  rd_mux = REG_W'(stat);
      W_PEND:  rd_mux = REG_W'(pend);
      W_ENA:   rd_mux = REG_W'(ena);
      W_VEC:   rd_mux = vec_any ? REG_W'(vec_idx) : '1;
      W_MST:   rd_mux = {{(REG_W-2){1'b0}}, hw_en, req_en};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= req_en & vec_any;
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(req_en && (stat & ena) != '0))); // R9
  AST_VEC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_any |-> pend[vec_idx]); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R11

  if (NUM_SRC < REG_W) begin : g_upper_chk
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && (sel == W_STAT || sel == W_PEND || sel == W_ENA))
      |=> (rd_data_o[REG_W-1:NUM_SRC] == '0)); // R10
  end
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  localparam int N = 20;
  localparam logic [31:0] EDGE = 32'h0000_00F0;
  localparam logic [31:0] MASK = (32'h1 << N) - 32'h1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [N-1:0] src = '0;
  logic        irq;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.NUM_SRC(N), .SRC_EDGE(EDGE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .src_i(src), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_st = '0, m_en = '0, m_prev = '0;
  logic        m_me = 1'b0, m_hie = 1'b0;

  function automatic logic [31:0] exp_read(logic [2:0] a);
    logic [31:0] p = m_st & m_en;
    case (a)
      3'd0: return m_st;
      3'd1: return p;
      3'd2: return m_en;
      3'd6: begin
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
      end
      3'd7: return {30'b0, m_hie, m_me};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd6: return "R7";
      3'd7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(bit we, logic [2:0] a, logic [31:0] d, bit re,
                     logic [31:0] s, string tag = "");
    logic [31:0] exp_rd, evt, ack, sws;
    logic        exp_irq;
    wr_en = we; addr = a; wdata = d; rd_en = re; src = s[N-1:0];
    @(posedge clk);
    exp_irq = m_me & ((m_st & m_en) != 0);
    exp_rd  = exp_read(a);
    evt  = (((s & ~EDGE) | (s & ~m_prev & EDGE))) & MASK;
    ack  = (we && a == 3'd3) ? (d & MASK) : 32'h0;
    sws  = (we && a == 3'd0 && !m_hie) ? (d & MASK) : 32'h0;
    m_st = (m_st & ~ack) | sws | (m_hie ? evt : 32'h0);
    if (we) begin
      case (a)
        3'd2: m_en = d & MASK;
        3'd4: m_en = m_en | (d & MASK);
        3'd5: m_en = m_en & ~d;
        3'd7: begin m_me = d[0]; m_hie = m_hie | d[1]; end
        default: ;
      endcase
    end
    m_prev = s & MASK;
    @(negedge clk);
    check("R9", {31'b0, irq}, {31'b0, exp_irq});
    if (re) check((tag != "") ? tag : tag_of(a), rd_data, exp_rd);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic [31:0] s = '0);
    cyc(1'b1, a, d, 1'b0, s);
  endtask

  task automatic rd(logic [2:0] a, string tag, logic [31:0] s = '0);
    cyc(1'b0, a, 32'h0, 1'b1, s, tag);
  endtask

  task automatic rand_phase(int cycles, bit allow_hie);
    for (int k = 0; k < cycles; k++) begin
      logic [2:0]  a = 3'($urandom % 8);
      logic [31:0] d = $urandom;
      bit          we = ($urandom % 3) == 0;
      if (a == 3'd7 && !allow_hie) d = d & 32'h1;
      cyc(we, a, d, ($urandom % 4) != 0, $urandom & $urandom & $urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every word and of the request
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    // R3: software raises test interrupts before hardware takes over
    wr(3'd0, 32'hFFF0_0005);
    rd(3'd0, "R3");
    // R10: upper bits ignored and read as zero
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, "R10");
    rd(3'd0, "R10");
    // R5: clear and set aliases touch only the written bits
    wr(3'd5, 32'hFFFF_FFFA);
    rd(3'd2, "R5");
    wr(3'd4, 32'h0000_0100);
    rd(3'd2, "R5");
    rd(3'd4, "R11");
    // R4: pending ignores writes
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, "R4");
    rd(3'd6, "R7");
    // R9: request rises one edge after enabling
    wr(3'd7, 32'h1);
    rd(3'd7, "R8");
    rd(3'd6, "R9");
    // R6/R7: acknowledge bit 0, vector moves to bit 2
    wr(3'd3, 32'h1);
    rd(3'd6, "R7");
    rd(3'd3, "R6");
    wr(3'd3, 32'h4);
    rd(3'd6, "R7");
    rand_phase(1500, 1'b0);
    // R8: hardware enable is sticky
    wr(3'd7, 32'h3);
    wr(3'd7, 32'h1);
    rd(3'd7, "R8");
    // R3: status writes ignored once hardware owns it
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_0008);
    rd(3'd0, "R3");
    // R2: edge source bit 5 held high sets once; after ack stays clear
    wr(3'd2, 32'hFFFF_FFFF, 32'h20);
    rd(3'd0, "R2", 32'h20);
    wr(3'd3, 32'h20, 32'h20);
    rd(3'd0, "R2", 32'h20);
    // R2: level source bit 9 stays set after ack while high (R6 precedence)
    wr(3'd3, 32'h200, 32'h200);
    rd(3'd0, "R6", 32'h200);
    rd(3'd6, "R7", 32'h0);
    wr(3'd3, 32'h200);
    rd(3'd0, "R6");
    rand_phase(3000, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule